// File: doc/BRIEF.md
# Ping-Pong 7:1 DDR Serializer

This block turns a stream of wide parallel words, one per rising edge of a slow clock, into four serial lanes of 7 bits each plus a framing lane. The serial side runs on a fast clock that is 3.5 times the slow rate and is phase aligned with it. Each fast cycle it hands two bits per lane to an external double-data-rate output cell: one for the first half-cycle and one for the second. Since 7 bits fill 3.5 fast cycles, two words take exactly 7 fast cycles. The second word of each pair starts in the second half of the fourth cycle.

Words cross from the slow domain to the fast domain through a two-entry buffer. The slow side fills the two entries in turn. The fast side reads an entry only while the slow side is not writing it. This works only because both clocks keep a fixed phase relation. An external aligner states that relation with two inputs. `align_lock` says the clocks are phase locked. `align_mark` is a one-cycle pulse on the fast edge that coincides with a slow edge writing entry 0. Until the aligner has locked and marked, every output is held low.

Top module: `ser7_ddr`

## Requirements
- R1: After reset, each slow rising edge stores `din` into buffer entry 0 and then entry 1, alternating. The first word stored after reset goes to entry 0.
- R2: Lane L carries bits `din[7L+6:7L]`, most significant bit first. In each fast cycle `dq_first[L]` is the earlier bit and `dq_second[L]` the next one.
- R3: Two consecutive words fill exactly 7 fast cycles. In the fourth cycle of each group, the first slot carries bit 0 of the earlier word and the second slot carries bit 6 of the later word.
- R4: The mark is taken on a fast edge where `align_lock` and `align_mark` are both high. The outputs registered on the next fast edge carry bits 6 and 5 of the word stored in entry 0 at the marked edge. Words then follow in the order they were written.
- R5: For every word, the framing lane sends the 7-bit pattern 1100011 in the same slots as bits 6 down to 0 of the data lanes.
- R6: Before the first mark, all outputs are 0, including the framing lane. A mark while `align_lock` is low is ignored. A high `align_lock` without a mark also leaves the outputs at 0.
- R7: If `align_lock` is sampled low on a fast edge, all outputs are 0 after that edge. They stay 0 until a new mark is taken.
- R8: A mark taken while already locked restarts the slot sequence at the word start. At the nominal phase the serial stream continues without a break. After a lock loss, a new mark restarts output with the word written at that marked edge.
- R9: Driving `rst_n` low clears all outputs at once, without waiting for a clock edge. After `rst_n` rises, each clock domain leaves reset on its own third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Slow word clock |
| clk_f | input | 1 | Fast bit clock, 3.5x slow, phase aligned |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 28 | Parallel word, captured on each slow rising edge |
| align_lock | input | 1 | Aligner reports phase lock (fast domain) |
| align_mark | input | 1 | Pulse on the fast edge coinciding with an entry-0 write |
| dq_first | output | 4 | Per-lane bit for the first half of the fast cycle |
| dq_second | output | 4 | Per-lane bit for the second half of the fast cycle |
| fr_first | output | 1 | Framing lane, first half-cycle bit |
| fr_second | output | 1 | Framing lane, second half-cycle bit |

## Verification
The bench checks the serial stream for two words whose bits are distinct and asymmetric, with the straddling fourth cycle as the main target. A multiplexer that drew both straddle bits from one entry would repeat or lose a bit there. Writes that did not alternate, or a read side that looked at the entry being written, would show the wrong word in the first or last three cycles of a group. The bench also marks while already locked and checks that the stream does not break. It checks the gating cases: a mark without lock, lock without a mark, lock loss, and relock onto a later word. Here a design with sticky lock or a free-running slot counter would show data where zeros belong, or a stream that is out of phase.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  localparam int LANES_DEF = 4;
  localparam int BITS_DEF  = 7;
  localparam logic [6:0] FRAME_DEF = 7'b1100011;

  typedef struct packed {
    logic first;
    logic second;
  } ddr_pair_t;
endpackage

// File: rtl/ser_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release reset conditioner.
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ser_wr_side.sv
`timescale 1ns/1ps
// Slow-domain half of the ping-pong buffer (R1).
module ser_wr_side #(
  parameter int WORDW = 28
) (
  input  logic             clk_s,
  input  logic             rst_s_n,
  input  logic [WORDW-1:0] din,
  output logic [WORDW-1:0] ent0,
  output logic [WORDW-1:0] ent1,
  output logic             wr_sel
);
  logic [1:0][WORDW-1:0] ent_q, ent_d;
  logic                  sel_q, sel_d;
  logic                  wr_en;

  assign wr_en = 1'b1;

  always_comb begin
    ent_d = ent_q;
    sel_d = sel_q;
    if (wr_en) begin
      ent_d[sel_q] = din;
      sel_d        = ~sel_q;
    end
  end

  always_ff @(posedge clk_s or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ent_q <= '0;
      sel_q <= 1'b0;
    end else begin
      ent_q <= ent_d;
      sel_q <= sel_d;
    end
  end

  assign ent0   = ent_q[0];
  assign ent1   = ent_q[1];
  assign wr_sel = sel_q;
endmodule

// File: rtl/ser_phase.sv
`timescale 1ns/1ps
// Fast-domain lock state and slot counter (R4, R6, R7, R8).
module ser_phase #(
  parameter int BITS = 7,
  localparam int SW  = $clog2(BITS)
) (
  input  logic          clk_f,
  input  logic          rst_f_n,
  input  logic          align_lock,
  input  logic          align_mark,
  output logic          lock_q,
  output logic [SW-1:0] slot_q,
  output logic          out_en
);
  localparam logic [SW-1:0] LAST = SW'(BITS - 1);

  logic          lock_d;
  logic [SW-1:0] slot_d;
  logic          take_mark;

  always_comb begin
    take_mark = align_lock & align_mark;
    lock_d    = align_lock & (lock_q | align_mark);
    if (take_mark)           slot_d = '0;
    else if (slot_q == LAST) slot_d = '0;
    else                     slot_d = slot_q + SW'(1);
  end

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      lock_q <= 1'b0;
      slot_q <= '0;
    end else begin
      lock_q <= lock_d;
      slot_q <= slot_d;
    end
  end

  assign out_en = lock_q & align_lock;
endmodule

// File: rtl/ser_slot_mux.sv
`timescale 1ns/1ps
// Picks the two DDR bits of every lane for the current slot (R2, R3, R5).
module ser_slot_mux #(
  parameter int LANES = 4,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] FRAME = 7'b1100011,
  localparam int SW    = $clog2(BITS),
  localparam int WORDW = LANES * BITS
) (
  input  logic [WORDW-1:0]                   ent0,
  input  logic [WORDW-1:0]                   ent1,
  input  logic [SW-1:0]                      slot,
  output ser_pkg::ddr_pair_t [LANES-1:0]     lane_pair,
  output ser_pkg::ddr_pair_t                 frm_pair
);
  localparam int            HALF   = (BITS - 1) / 2;
  localparam logic [SW-1:0] HALF_S = SW'(HALF);

  // x is the word sent first (entry 0), y the word sent second (entry 1).
  function automatic ser_pkg::ddr_pair_t pick(input logic [BITS-1:0] x,
                                              input logic [BITS-1:0] y,
                                              input logic [SW-1:0]   s);
    ser_pkg::ddr_pair_t r;
    logic [SW-1:0] ia;
    logic [SW-1:0] ib;
    ia = '0;
    ib = '0;
    if (s < HALF_S) begin
      ia       = SW'(BITS - 1 - 2 * int'(s));
      ib       = ia - SW'(1);
      r.first  = x[ia];
      r.second = x[ib];
    end else if (s == HALF_S) begin
      // straddling slot: last bit of one entry, first bit of the other
      r.first  = x[0];
      r.second = y[BITS-1];
    end else begin
      ia       = SW'(BITS - 2 - 2 * (int'(s) - HALF - 1));
      ib       = ia - SW'(1);
      r.first  = y[ia];
      r.second = y[ib];
    end
    return r;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_pair[g] = pick(ent0[g*BITS +: BITS], ent1[g*BITS +: BITS], slot);
  end

  assign frm_pair = pick(FRAME, FRAME, slot);
endmodule

// File: rtl/ser7_ddr.sv
`timescale 1ns/1ps
module ser7_ddr #(
  parameter int LANES = ser_pkg::LANES_DEF,
  parameter int BITS  = ser_pkg::BITS_DEF,
  parameter logic [BITS-1:0] FRAME = BITS'(ser_pkg::FRAME_DEF),
  localparam int WORDW = LANES * BITS,
  localparam int SW    = $clog2(BITS)
) (
  input  logic             clk_s,
  input  logic             clk_f,
  input  logic             rst_n,
  input  logic [WORDW-1:0] din,
  input  logic             align_lock,
  input  logic             align_mark,
  output logic [LANES-1:0] dq_first,
  output logic [LANES-1:0] dq_second,
  output logic             fr_first,
  output logic             fr_second
);
  logic rst_s_n, rst_f_n;
  logic [WORDW-1:0] ent0, ent1;
  logic wr_sel;
  logic lock_q, out_en;
  logic [SW-1:0] slot_q;
  ser_pkg::ddr_pair_t [LANES-1:0] lane_pair;
  ser_pkg::ddr_pair_t             frm_pair;

  logic [LANES-1:0] dqa_d, dqb_d;
  logic             fra_d, frb_d;

  ser_rst_sync #(.STAGES(2)) u_rs_s (.clk(clk_s), .arst_n(rst_n), .srst_n(rst_s_n));
  ser_rst_sync #(.STAGES(2)) u_rs_f (.clk(clk_f), .arst_n(rst_n), .srst_n(rst_f_n));

  ser_wr_side #(.WORDW(WORDW)) u_wr (
    .clk_s(clk_s), .rst_s_n(rst_s_n), .din(din),
    .ent0(ent0), .ent1(ent1), .wr_sel(wr_sel)
  );

  ser_phase #(.BITS(BITS)) u_ph (
    .clk_f(clk_f), .rst_f_n(rst_f_n),
    .align_lock(align_lock), .align_mark(align_mark),
    .lock_q(lock_q), .slot_q(slot_q), .out_en(out_en)
  );

  ser_slot_mux #(.LANES(LANES), .BITS(BITS), .FRAME(FRAME)) u_mux (
    .ent0(ent0), .ent1(ent1), .slot(slot_q),
    .lane_pair(lane_pair), .frm_pair(frm_pair)
  );

  // Output stage: both DDR inputs updated together on the fast rising edge.
  always_comb begin
    dqa_d = '0;
    dqb_d = '0;
    fra_d = 1'b0;
    frb_d = 1'b0;
    if (out_en) begin
      for (int l = 0; l < LANES; l++) begin
        dqa_d[l] = lane_pair[l].first;
        dqb_d[l] = lane_pair[l].second;
      end
      fra_d = frm_pair.first;
      frb_d = frm_pair.second;
    end
  end

  always_ff @(posedge clk_f or negedge rst_f_n) begin
    if (!rst_f_n) begin
      dq_first  <= '0;
      dq_second <= '0;
      fr_first  <= 1'b0;
      fr_second <= 1'b0;
    end else begin
      dq_first  <= dqa_d;
      dq_second <= dqb_d;
      fr_first  <= fra_d;
      fr_second <= frb_d;
    end
  end
endmodule

// File: rtl/ser7_ddr_chk.sv
`timescale 1ns/1ps
module ser7_ddr_chk #(
  parameter int LANES = 4,
  parameter int BITS  = 7,
  parameter logic [BITS-1:0] FRAME = 7'b1100011,
  localparam int SW = $clog2(BITS)
) (
  input logic             clk_s,
  input logic             clk_f,
  input logic             rst_s_n,
  input logic             rst_f_n,
  input logic             align_lock,
  input logic             align_mark,
  input logic             lock_q,
  input logic [SW-1:0]    slot_q,
  input logic             wr_sel,
  input logic [LANES-1:0] dq_first,
  input logic [LANES-1:0] dq_second,
  input logic             fr_first,
  input logic             fr_second
);
  p_alt_hi_r1: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    wr_sel |=> !wr_sel);
  p_alt_lo_r1: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    !wr_sel |=> wr_sel);

  p_slot_range_r3: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    slot_q <= SW'(BITS - 1));

  p_frame_head_r5: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (lock_q && align_lock && slot_q == '0) |=>
      (fr_first == FRAME[BITS-1] && fr_second == FRAME[BITS-2]));

  p_unlocked_zero_r6: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    !lock_q |=> (dq_first == '0 && dq_second == '0 && !fr_first && !fr_second));

  p_drop_zero_r7: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    !align_lock |=> (dq_first == '0 && dq_second == '0 && !fr_first && !fr_second));

  p_mark_restart_r8: assert property (@(posedge clk_f) disable iff (!rst_f_n)
    (align_lock && align_mark) |=> (slot_q == '0 && lock_q));
endmodule

bind ser7_ddr ser7_ddr_chk #(.LANES(LANES), .BITS(BITS), .FRAME(FRAME)) u_chk (
  .clk_s(clk_s), .clk_f(clk_f), .rst_s_n(rst_s_n), .rst_f_n(rst_f_n),
  .align_lock(align_lock), .align_mark(align_mark),
  .lock_q(lock_q), .slot_q(slot_q), .wr_sel(wr_sel),
  .dq_first(dq_first), .dq_second(dq_second),
  .fr_first(fr_first), .fr_second(fr_second)
);

// File: tb/sim_ser7_ddr.sv
`timescale 1ns/1ps
module sim_ser7_ddr;
  localparam int FAST_PERIOD = 4;              // ns
  localparam int SLOW_PERIOD = FAST_PERIOD * 7 / 2;
  localparam int LANES = 4;
  localparam int BITS  = 7;
  localparam int NV    = 12;
  localparam logic [6:0] FRM = 7'b1100011;
  localparam logic [27:0] VEC [NV] = '{
    28'hFFFFFFF, 28'h0000000, 28'hAAAAAAA, 28'h5555555,
    28'h8102040, 28'h0204081, 28'hFEDCBA9, 28'h1234567,
    28'hC3C3C3C, 28'h0F0F0F0, 28'h7FFFFFE, 28'h8000001
  };

  logic clk_s, clk_f, rst_n, align_lock, align_mark;
  logic [27:0] din;
  logic [3:0] dq_first, dq_second;
  logic fr_first, fr_second;
  int t_abs;
  int total, bad;
  bit done;

  ser7_ddr u0 (
    .clk_s(clk_s), .clk_f(clk_f), .rst_n(rst_n), .din(din),
    .align_lock(align_lock), .align_mark(align_mark),
    .dq_first(dq_first), .dq_second(dq_second),
    .fr_first(fr_first), .fr_second(fr_second)
  );

  // Fast rises at t%4==2, slow rises at t%14==2: coincident every 28 ns.
  initial begin
    t_abs = 0; clk_f = 1'b0; clk_s = 1'b0;
    forever begin
      #1;
      t_abs++;
      clk_f = ((t_abs % FAST_PERIOD) >= FAST_PERIOD / 2);
      clk_s = (((t_abs + SLOW_PERIOD - 2) % SLOW_PERIOD) < SLOW_PERIOD / 2);
    end
  end

  task automatic till(input int n);
    wait (t_abs >= n);
  endtask

  function automatic logic [27:0] word_at(input int i);
    if (i >= 0 && i < NV) return VEC[i];
    return 28'((i * 32'h9E3779B1) ^ 32'h0ABCDEF);
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at t=%0d: got %h expected %h", tag, t_abs, act, exp);
    end
  endtask

  function automatic logic [9:0] obs();
    return {dq_first, dq_second, fr_first, fr_second};
  endfunction

  // Expected data pair of cycle j after a mark whose first word index is kb.
  function automatic logic [9:0] exp_pair(input int kb, input int j);
    logic [3:0] a, b;
    logic [27:0] w0, w1;
    int g0, g1, p0, p1;
    g0 = 2 * j; g1 = 2 * j + 1;
    w0 = word_at(kb + g0 / 7); p0 = 6 - g0 % 7;
    w1 = word_at(kb + g1 / 7); p1 = 6 - g1 % 7;
    for (int l = 0; l < LANES; l++) begin
      a[l] = w0[l * BITS + p0];
      b[l] = w1[l * BITS + p1];
    end
    return {a, b, FRM[p0], FRM[p1]};
  endfunction

  task automatic stream(input int tm, input int ncyc, input string tag);
    int kb;
    logic [9:0] e, o;
    string tg;
    kb = (tm - 86) / 14;
    for (int j = 0; j < ncyc; j++) begin
      till(tm + 6 + 4 * j);
      e = exp_pair(kb, j);
      o = obs();
      if (j == 0)                   tg = "R4 first pair";
      else if (j % 7 == 3)          tg = "R3 straddle";
      else if (tm == 86 && j == 21) tg = "R8 in-phase re-mark";
      else                          tg = tag;
      check(tg, {o[9:2], 2'b00}, {e[9:2], 2'b00});
      check("R5 frame", {8'h00, o[1:0]}, {8'h00, e[1:0]});
    end
  endtask

  // Word feeder: word i is stored at slow edge 86+14*i.
  initial begin
    din = '0;
    for (int i = -2; i < 40; i++) begin
      till(79 + 14 * i);
      din = word_at(i);
    end
  end

  // In-phase mark while locked, at a coincident edge (170).
  initial begin
    till(168); align_mark = 1'b1;
    till(172); align_mark = 1'b0;
  end

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rst_n = 1'b0; align_lock = 1'b0; align_mark = 1'b0;
    till(20);
    check("R9 reset state", obs(), 10'h000);
    till(49); rst_n = 1'b1;
    till(60); align_mark = 1'b1;
    till(64); align_mark = 1'b0;
    till(68);
    check("R6 mark without lock", obs(), 10'h000);
    till(80); align_lock = 1'b1;
    till(84);
    check("R6 lock without mark", obs(), 10'h000);
    align_mark = 1'b1;
    till(88); align_mark = 1'b0;
    stream(86, 42, "R2 R1 lane order");
    align_lock = 1'b0;
    till(260);
    check("R7 lock dropped", obs(), 10'h000);
    till(280);
    check("R7 stays zero", obs(), 10'h000);
    till(300); align_lock = 1'b1;
    till(308);
    check("R6 relock needs mark", obs(), 10'h000);
    align_mark = 1'b1;
    till(312); align_mark = 1'b0;
    stream(310, 14, "R8 relock");
    till(400); rst_n = 1'b0;
    till(401);
    check("R9 async clear", obs(), 10'h000);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule